// File: doc/BRIEF.md
# Staircase PWM Test Stimulus Generator

This block drives a single-bit pulse-width modulated line whose duty cycle climbs in equal increments from zero to full scale. An external low-pass filter turns the bit into a slowly rising staircase that sweeps the whole input range of an analog-to-digital converter under test. The four quarters of the sweep line up with the four accumulation windows of a downstream polynomial-fit analysis.

The PWM period is a fixed power of two in clocks and is re-aligned by every converter sample strobe. A programmable delay sets where, after each strobe, the period starts again. The filter ripple therefore falls at the same point of every conversion. Software sets the number of increments as a power of two and how many strobes each level lasts, then issues a start pulse. The block reports the current level index, a busy flag and a one-clock completion pulse.

Top module: `pwm_stair_gen`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `pwm_o`, `busy_o` and `done_o` are 0 and `step_idx_o` is 0.
- R2: A `start_i` sampled while idle makes `busy_o` 1 and `step_idx_o` 0 from the next cycle. The step configuration is captured at that edge.
- R3: A `start_i` sampled while `busy_o` is 1 has no effect. This includes the edge that ends the sweep: the level sequence continues unchanged, and once `done_o` has pulsed the block stays idle.
- R4: For `steps_log_i` = L, clamped to the range 2..DUTY_W, the sweep has 2^L increments and 2^L+1 levels with indices 0..2^L. Level k has duty value k·2^(DUTY_W−L), so level 0 is 0 and level 2^L is 2^DUTY_W. Every quarter boundary falls on an index that is a multiple of 2^(L−2).
- R5: While busy, each level lasts `sps_i` sample strobes (0 is treated as 1). The index advances at the edge that samples the last of those strobes. Strobes seen while idle do not count.
- R6: The PWM period is 2^DUTY_W clocks. `pwm_o` is 1 exactly when busy and the period position is less than the current level's duty value. While idle `pwm_o` is 0.
- R7: When a strobe is sampled at edge e with `phase_i` = P, the period position is 0 in the cycle after edge e+P. It then counts up by one per clock and wraps.
- R8: At the edge that samples the final level's last strobe, `busy_o` falls, `done_o` is 1 for exactly one cycle, and `step_idx_o` holds 2^L until the next start.
- R9: Throughout the final level (index 2^L), `pwm_o` stays 1 for whole periods.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start a sweep (ignored while busy) |
| strobe_i | input | 1 | Converter sample strobe, one cycle per sample |
| steps_log_i | input | LOG_W | log2 of the number of increments |
| sps_i | input | SPS_W | Sample strobes per level |
| phase_i | input | DUTY_W | Clocks from strobe to period restart |
| pwm_o | output | 1 | PWM bit |
| step_idx_o | output | DUTY_W+1 | Current level index |
| busy_o | output | 1 | Sweep in progress |
| done_o | output | 1 | One-cycle end-of-sweep pulse |

## Verification
The sweep can end at the same edge that samples a start request, because the final strobe and a start can arrive together. The bench raises `start_i` in the very cycle it raises the last strobe. It then expects the completion pulse and afterwards a block that stays idle with the index frozen at full scale and the output low. A second start inside the first increment is checked the same way against the unchanged level sequence. Every cycle of each sweep is compared with a duty and phase position computed arithmetically, over several step counts, clamped settings, strobe counts and phase offsets.

// File: rtl/pwm_stair_pkg.sv
package pwm_stair_pkg;
   // restrict the requested increment exponent so that quarters are whole levels
   function automatic int clamp_log(input int req, input int width);
      int r;
      r = req;
      if (r < 2) r = 2;
      if (r > width) r = width;
      return r;
   endfunction
endpackage

// File: rtl/pwm_phase_sync.sv
module pwm_phase_sync #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         strobe_i,
   input  logic [W-1:0] phase_i,
   output logic [W-1:0] cnt_o
);
   localparam logic [W-1:0] ONE = W'(1);

   logic [W-1:0] cnt_q;
   logic [W-1:0] dly_q;
   logic         armed_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         dly_q   <= '0;
         armed_q <= 1'b0;
      end else if (strobe_i) begin
         if (phase_i == '0) begin
            cnt_q   <= '0;
            armed_q <= 1'b0;
         end else begin
            cnt_q   <= cnt_q + ONE;
            dly_q   <= phase_i - ONE;
            armed_q <= 1'b1;
         end
      end else if (armed_q && dly_q == '0) begin
         cnt_q   <= '0;
         armed_q <= 1'b0;
      end else begin
         cnt_q <= cnt_q + ONE;
         if (armed_q) dly_q <= dly_q - ONE;
      end
   end

   assign cnt_o = cnt_q;

   p_phase_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (strobe_i && phase_i == '0) |=> cnt_q == '0);

   p_period_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!strobe_i && !armed_q && (&cnt_q)) |=> cnt_q == '0);
endmodule

// File: rtl/pwm_step_seq.sv
module pwm_step_seq #(
   parameter int W     = 8,
   parameter int SPS_W = 8,
   parameter int LOG_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic             strobe_i,
   input  logic [LOG_W-1:0] steps_log_i,
   input  logic [SPS_W-1:0] sps_i,
   output logic             busy_o,
   output logic             done_o,
   output logic [W:0]       idx_o,
   output logic [LOG_W-1:0] shift_o
);
   import pwm_stair_pkg::*;

   localparam logic [W:0]       IDX_ONE = (W+1)'(1);
   localparam logic [SPS_W-1:0] CNT_ONE = SPS_W'(1);

   logic             busy_q, done_q;
   logic [W:0]       idx_q;
   logic [SPS_W-1:0] scnt_q, sps_q;
   logic [LOG_W-1:0] lvl_q;
   logic [LOG_W-1:0] lvl_req;
   logic [SPS_W-1:0] sps_req;
   logic [W:0]       last_w;
   logic             level_end;

   always_comb begin
      lvl_req   = LOG_W'(clamp_log(int'(steps_log_i), W));
      sps_req   = (sps_i == '0) ? CNT_ONE : sps_i;
      last_w    = IDX_ONE << lvl_q;
      level_end = (scnt_q == sps_q - CNT_ONE);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         done_q <= 1'b0;
         idx_q  <= '0;
         scnt_q <= '0;
         sps_q  <= CNT_ONE;
         lvl_q  <= LOG_W'(W);
      end else begin
         done_q <= 1'b0;
         if (!busy_q) begin
            if (start_i) begin
               busy_q <= 1'b1;
               idx_q  <= '0;
               scnt_q <= '0;
               sps_q  <= sps_req;
               lvl_q  <= lvl_req;
            end
         end else if (strobe_i) begin
            if (level_end) begin
               scnt_q <= '0;
               if (idx_q == last_w) begin
                  busy_q <= 1'b0;
                  done_q <= 1'b1;
               end else begin
                  idx_q <= idx_q + IDX_ONE;
               end
            end else begin
               scnt_q <= scnt_q + CNT_ONE;
            end
         end
      end
   end

   assign busy_o  = busy_q;
   assign done_o  = done_q;
   assign idx_o   = idx_q;
   assign shift_o = LOG_W'(W) - lvl_q;

   p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |=> !done_q);

   p_done_after_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |-> (!busy_q && $past(busy_q)));

   p_start_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && start_i && !strobe_i) |=> (busy_q && $stable(idx_q)));

   p_idx_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q |-> idx_q <= last_w);

   p_hold_level_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && !strobe_i) |=> ($stable(idx_q) && $stable(scnt_q)));
endmodule

// File: rtl/pwm_stair_gen.sv
module pwm_stair_gen #(
   parameter  int DUTY_W = 8,
   parameter  int SPS_W  = 8,
   localparam int LOG_W  = $clog2(DUTY_W + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              strobe_i,
   input  logic [LOG_W-1:0]  steps_log_i,
   input  logic [SPS_W-1:0]  sps_i,
   input  logic [DUTY_W-1:0] phase_i,
   output logic              pwm_o,
   output logic [DUTY_W:0]   step_idx_o,
   output logic              busy_o,
   output logic              done_o
);
   if (DUTY_W < 2) begin : g_bad_duty_w
      $error("pwm_stair_gen: DUTY_W must be at least 2");
   end
   if (SPS_W < 1) begin : g_bad_sps_w
      $error("pwm_stair_gen: SPS_W must be at least 1");
   end

   logic [DUTY_W-1:0] pos_w;
   logic [DUTY_W:0]   idx_w;
   logic [DUTY_W:0]   duty_w;
   logic [LOG_W-1:0]  shift_w;
   logic              busy_w;

   pwm_phase_sync #(.W(DUTY_W)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .strobe_i (strobe_i),
      .phase_i  (phase_i),
      .cnt_o    (pos_w)
   );

   pwm_step_seq #(.W(DUTY_W), .SPS_W(SPS_W), .LOG_W(LOG_W)) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_i     (start_i),
      .strobe_i    (strobe_i),
      .steps_log_i (steps_log_i),
      .sps_i       (sps_i),
      .busy_o      (busy_w),
      .done_o      (done_o),
      .idx_o       (idx_w),
      .shift_o     (shift_w)
   );

   always_comb begin
      duty_w = idx_w << shift_w;
      pwm_o  = busy_w && ({1'b0, pos_w} < duty_w);
   end

   assign step_idx_o = idx_w;
   assign busy_o     = busy_w;
endmodule

// File: tb/pwm_stair_gen_test.sv
`timescale 1ns/1ps
module pwm_stair_gen_test;
   localparam int W = 4;
   localparam int P = 16;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start_i = 1'b0;
   logic       strobe_i = 1'b0;
   logic [2:0] steps_log_i = 3'd2;
   logic [2:0] sps_i = 3'd1;
   logic [3:0] phase_i = 4'd0;
   logic       pwm_o;
   logic [4:0] step_idx_o;
   logic       busy_o;
   logic       done_o;

   int tests = 0;
   int fails = 0;
   bit finished = 0;

   always #2 clk = ~clk;

   pwm_stair_gen #(.DUTY_W(W), .SPS_W(3)) uut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .strobe_i(strobe_i),
      .steps_log_i(steps_log_i), .sps_i(sps_i), .phase_i(phase_i),
      .pwm_o(pwm_o), .step_idx_o(step_idx_o), .busy_o(busy_o), .done_o(done_o)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
      end
   endtask

   // one sweep: windows follow each strobe edge, 16 cycles apart
   task automatic run(input int l_req, input int s_req, input int ph, input bit collide);
      int le, se, total, last, bexp, iexp, duty, pos;
      string preq;
      le = (l_req < 2) ? 2 : ((l_req > W) ? W : l_req);
      se = (s_req == 0) ? 1 : s_req;
      total = ((1 << le) + 1) * se;
      last = 1 << le;
      steps_log_i = 3'(l_req);
      sps_i = 3'(s_req);
      phase_i = 4'(ph);
      for (int w = -2; w <= total + 1; w++) begin
         for (int j = 0; j < P; j++) begin
            @(negedge clk);
            pos = ((j - ph) % P + P) % P;
            if (w < 0) begin
               chk(pwm_o == 1'b0, "R6", "idle pwm", int'(pwm_o), 0);
               chk(busy_o == 1'b0, "R2", "idle busy", int'(busy_o), 0);
            end else if (w == 0) begin
               bexp = (j >= 7) ? 1 : 0;
               chk(busy_o == bexp[0], "R2", "busy after start", int'(busy_o), bexp);
               if (j >= 7) chk(step_idx_o == 5'd0, "R2", "index after start", int'(step_idx_o), 0);
               chk(pwm_o == 1'b0, "R4", "level 0 pwm", int'(pwm_o), 0);
            end else begin
               bexp = (w < total) ? 1 : 0;
               iexp = (w < total) ? (w / se) : last;
               duty = iexp << (W - le);
               preq = (iexp == last) ? "R9" : ((ph != 0) ? "R7" : "R6");
               if (w >= total) preq = (w == total + 1) ? "R3" : "R8";
               chk(busy_o == bexp[0], (w >= total) ? "R8" : "R3", "busy", int'(busy_o), bexp);
               chk(done_o == ((w == total) && (j == 0)), "R8", "done", int'(done_o),
                   ((w == total) && (j == 0)) ? 1 : 0);
               if (j == 0) chk(step_idx_o == 5'(iexp), (se > 1) ? "R5" : "R4", "index",
                               int'(step_idx_o), iexp);
               chk(pwm_o == ((bexp == 1) && (pos < duty)), preq, "pwm", int'(pwm_o),
                   ((bexp == 1) && (pos < duty)) ? 1 : 0);
            end
            strobe_i = (j == P - 1);
            start_i = ((w == 0) && (j == 6)) || ((w == 1) && (j == 3)) ||
                      (collide && (w == total - 1) && (j == P - 1));
         end
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk(pwm_o == 1'b0 && busy_o == 1'b0 && done_o == 1'b0 && step_idx_o == 5'd0,
          "R1", "outputs in reset", int'({pwm_o, busy_o, done_o}), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(busy_o == 1'b0 && done_o == 1'b0 && step_idx_o == 5'd0, "R1", "outputs after reset",
          int'(step_idx_o), 0);
      strobe_i = 1'b1;
      run(2, 1, 0, 1'b1);
      run(3, 2, 5, 1'b0);
      run(4, 1, 15, 1'b1);
      run(1, 2, 3, 1'b0);
      run(6, 1, 9, 1'b0);
      run(2, 0, 1, 1'b1);
      run(4, 3, 2, 1'b0);
      run(0, 4, 8, 1'b1);
      if (!finished) begin
         finished = 1;
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         tests++;
         fails++;
         $display("FAIL watchdog: actual 1 expected 0");
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end
endmodule